// File: doc/BRIEF.md
# Strobe-Terminated Serial Register Target

This block is the target end of a small serial register bus made of a serial clock, a data line from the host, an active-low strobe and a data line back to the host. The host bit-bangs each command most significant bit first. A command ends with one extra clock taken while the strobe is low; the data-line level on that clock picks the direction. A write carries a 32-bit value followed by an 8-bit address. A read carries only the 8-bit address, and the host then clocks out 32 result bits.

The block holds six registers. Three are writable configuration words: a mode word, a multiplexer word and a video word. One mirrors an external switch input. One is a reset control word, and writing exactly 1 to it raises a reset request to the system. The last is a read-only version word set by a parameter. All logic runs on the serial clock. The bus idles with the strobe high and with the clock and data line low.

Top module: `strobe_reg_target`

## Requirements
- R1: After a synchronous reset (rst_n low over at least one rising and one falling serial-clock edge), mode_cfg equals MODE_RESET, mux_cfg, video_cfg and the reset word are zero, sys_reset_req is 0 and ser_out is 0.
- R2: Write command: 32 data bits, then 8 address bits (each MSB first, sampled on rising edges with stb_n high), then one rising edge with stb_n low and ser_in 1. This stores the data in the register at that address. Writable addresses are 0x00 (mode), 0x01 (mux), 0x02 (video) and 0x80 (reset word).
- R3: Read command: 8 address bits, then one rising edge with stb_n low and ser_in 0. Bit 31 of the addressed word is on ser_out by the falling edge of that strobe clock. Each following falling edge with stb_n high moves to the next lower bit, so the host sees 32 bits MSB first, each valid before its rising edge.
- R4: Writes to the read-only addresses 0x08 and 0xFF, or to any unmapped address, change no register.
- R5: A read of any address other than 0x00, 0x01, 0x02, 0x08, 0x80 and 0xFF returns zero.
- R6: A read of address 0xFF returns the VERSION parameter.
- R7: A read of address 0x08 returns sw_in as resampled through two serial-clock flops.
- R8: sys_reset_req is 1 exactly while the reset word (address 0x80) holds the value 1. The reset word reads back as written.
- R9: Rising clock edges with stb_n high only shift the command register and never change a stored register.
- R10: The first transaction after reset completes correctly, so a version read right after reset returns VERSION.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ser_clk | input | 1 | Serial clock driven by the host |
| rst_n | input | 1 | Synchronous active-low reset |
| stb_n | input | 1 | Active-low strobe marking the direction clock |
| ser_in | input | 1 | Serial data from the host |
| sw_in | input | DATA_W | External switch word |
| ser_out | output | 1 | Serial read data to the host |
| mode_cfg | output | DATA_W | Mode register contents |
| mux_cfg | output | DATA_W | Multiplexer register contents |
| video_cfg | output | DATA_W | Video register contents |
| sys_reset_req | output | 1 | Reset request to the system |

## Verification
The bench builds the block with the default 32-bit data and 8-bit address widths and a VERSION and MODE_RESET of its own. With non-default values for these two, a mixed-up constant shows up in the readback. Because the address is only 8 bits wide, all 256 addresses can be swept with a distinct write pattern each, followed by a readback. This covers every mapped, read-only and unmapped case, including the decode of every address bit.

// File: rtl/srt_pkg.sv
// Package: address map and decode helpers shared by the serial register target.
// Assumes an 8-bit address field; the addresses are fixed by the bus protocol.
package srt_pkg;
    localparam logic [7:0] ADR_MODE  = 8'h00;
    localparam logic [7:0] ADR_MUX   = 8'h01;
    localparam logic [7:0] ADR_VIDEO = 8'h02;
    localparam logic [7:0] ADR_SW    = 8'h08;
    localparam logic [7:0] ADR_RST   = 8'h80;
    localparam logic [7:0] ADR_VER   = 8'hFF;

    // True for addresses that accept writes.
    function automatic logic is_writable(input logic [7:0] a);
        return (a == ADR_MODE) || (a == ADR_MUX) || (a == ADR_VIDEO) || (a == ADR_RST);
    endfunction
endpackage

// File: rtl/srt_cmd_capture.sv
// Module: command capture. A free-running shift register collects host bits on
// rising edges while the strobe is high. When the strobe is low, the register is
// held and the direction bit on ser_in qualifies a read or a write decode.
// Assumes: the host keeps the strobe low for exactly one rising edge per command.
module srt_cmd_capture #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb_n,
    input  logic              ser_in,
    output logic              wr_cmd,
    output logic              rd_cmd,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata
);
    localparam int FRAME_W = DATA_W + ADDR_W;

    logic [FRAME_W-1:0] frame_q;

    // Shift one host bit in per rising edge outside the strobe clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
        end else if (stb_n) begin
            frame_q <= {frame_q[FRAME_W-2:0], ser_in};
        end
    end

    // Decode direction on the strobe clock; the address is always the newest bits.
    always_comb begin
        wr_cmd = !stb_n && ser_in;
        rd_cmd = !stb_n && !ser_in;
        addr   = frame_q[ADDR_W-1:0];
        wdata  = frame_q[FRAME_W-1:ADDR_W];
    end
endmodule

// File: rtl/srt_regbank.sv
// Module: register bank. Holds the writable words, samples the switch input
// through two flops, builds the read word for the current address and drives
// the reset request.
// Assumes: wr_cmd is valid only on the strobe clock; the clock is the serial clock.
module srt_regbank
    import srt_pkg::*;
#(
    parameter int          DATA_W     = 32,
    parameter int          ADDR_W     = 8,
    parameter logic [31:0] VERSION    = 32'h0000_0001,
    parameter logic [31:0] MODE_RESET = 32'h0000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cmd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] sw_in,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] mode_o,
    output logic [DATA_W-1:0] mux_o,
    output logic [DATA_W-1:0] video_o,
    output logic              reset_req
);
    localparam logic [DATA_W-1:0] ONE_W = DATA_W'(1);

    logic [DATA_W-1:0] mode_q, mux_q, video_q, rstw_q;
    logic [DATA_W-1:0] sw_meta_q, sw_q;
    logic [7:0]        a8;

    assign a8 = 8'(addr);

    // Update the addressed writable word on a write decode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= DATA_W'(MODE_RESET);
            mux_q   <= '0;
            video_q <= '0;
            rstw_q  <= '0;
        end else if (wr_cmd) begin
            case (a8)
                ADR_MODE:  mode_q  <= wdata;
                ADR_MUX:   mux_q   <= wdata;
                ADR_VIDEO: video_q <= wdata;
                ADR_RST:   rstw_q  <= wdata;
                default:   ;
            endcase
        end
    end

    // Resample the switch input through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_meta_q <= '0;
            sw_q      <= '0;
        end else begin
            sw_meta_q <= sw_in;
            sw_q      <= sw_meta_q;
        end
    end

    // Select the read word for the current address; unmapped reads give zero.
    always_comb begin
        case (a8)
            ADR_MODE:  rdata = mode_q;
            ADR_MUX:   rdata = mux_q;
            ADR_VIDEO: rdata = video_q;
            ADR_SW:    rdata = sw_q;
            ADR_RST:   rdata = rstw_q;
            ADR_VER:   rdata = DATA_W'(VERSION);
            default:   rdata = '0;
        endcase
    end

    // Drive configuration outputs and the reset request.
    always_comb begin
        mode_o    = mode_q;
        mux_o     = mux_q;
        video_o   = video_q;
        reset_req = (rstw_q == ONE_W);
    end

    // R9: without a write decode nothing stored may change.
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_cmd |=> $stable({mode_q, mux_q, video_q, rstw_q}));

    // R4: writes to read-only or unmapped addresses leave all words alone.
    a_r4_ro_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && !is_writable(a8)) |=> $stable({mode_q, mux_q, video_q, rstw_q}));

    // R2: a mode write lands on the mode output one edge later.
    a_r2_mode_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && a8 == ADR_MODE) |=> (mode_o == $past(wdata)));

    // R8: writing 1 to the reset word raises the request.
    a_r8_req_on: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && a8 == ADR_RST && wdata == ONE_W) |=> reset_req);

    // R8: writing any other value drops the request.
    a_r8_req_off: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && a8 == ADR_RST && wdata != ONE_W) |=> !reset_req);
endmodule

// File: rtl/srt_tx_shifter.sv
// Module: read-data shifter. The read word is captured on the strobe rising
// edge. It is moved into the output shifter on the falling edge of the same
// strobe clock, so bit MSB is valid before the first data rising edge. Each later
// falling edge with the strobe high moves to the next lower bit.
// Assumes: the host raises the strobe only after lowering the clock.
module srt_tx_shifter #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb_n,
    input  logic              rd_cmd,
    input  logic [DATA_W-1:0] rdata,
    output logic              ser_out
);
    logic [DATA_W-1:0] ld_word_q;
    logic              ld_tok_q;
    logic              seen_tok_q;
    logic [DATA_W-1:0] out_q;

    // Capture the read word and flag a pending load on a read decode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_word_q <= '0;
            ld_tok_q  <= 1'b0;
        end else if (rd_cmd) begin
            ld_word_q <= rdata;
            ld_tok_q  <= !ld_tok_q;
        end
    end

    // Load on the strobe falling edge, then shift one bit per falling edge.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            out_q      <= '0;
            seen_tok_q <= 1'b0;
        end else if (!stb_n) begin
            if (seen_tok_q != ld_tok_q) begin
                out_q      <= ld_word_q;
                seen_tok_q <= ld_tok_q;
            end
        end else begin
            out_q <= {out_q[DATA_W-2:0], 1'b0};
        end
    end

    assign ser_out = out_q[DATA_W-1];

    // R3: the word captured on a read decode is the one the bank offered.
    a_r3_load_word: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cmd |=> (ld_word_q == $past(rdata)));
endmodule

// File: rtl/strobe_reg_target.sv
// Module: top of the strobe-terminated serial register target. Connects
// command capture, register bank and read shifter, all on the serial clock.
// Assumes: rst_n is synchronous to ser_clk and is held over clock edges.
module strobe_reg_target #(
    parameter int          DATA_W     = 32,
    parameter int          ADDR_W     = 8,
    parameter logic [31:0] VERSION    = 32'h0000_0001,
    parameter logic [31:0] MODE_RESET = 32'h0000_0000
) (
    input  logic              ser_clk,
    input  logic              rst_n,
    input  logic              stb_n,
    input  logic              ser_in,
    input  logic [DATA_W-1:0] sw_in,
    output logic              ser_out,
    output logic [DATA_W-1:0] mode_cfg,
    output logic [DATA_W-1:0] mux_cfg,
    output logic [DATA_W-1:0] video_cfg,
    output logic              sys_reset_req
);
    logic              wr_cmd, rd_cmd;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata, rdata;

    srt_cmd_capture #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_cap (
        .clk(ser_clk), .rst_n(rst_n), .stb_n(stb_n), .ser_in(ser_in),
        .wr_cmd(wr_cmd), .rd_cmd(rd_cmd), .addr(addr), .wdata(wdata)
    );

    srt_regbank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W),
                  .VERSION(VERSION), .MODE_RESET(MODE_RESET)) u_bank (
        .clk(ser_clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .addr(addr),
        .wdata(wdata), .sw_in(sw_in), .rdata(rdata), .mode_o(mode_cfg),
        .mux_o(mux_cfg), .video_o(video_cfg), .reset_req(sys_reset_req)
    );

    srt_tx_shifter #(.DATA_W(DATA_W)) u_tx (
        .clk(ser_clk), .rst_n(rst_n), .stb_n(stb_n), .rd_cmd(rd_cmd),
        .rdata(rdata), .ser_out(ser_out)
    );

    // R1: during reset the read line stays low after a falling edge.
    a_r1_reset_quiet: assert property (@(negedge ser_clk)
        !rst_n |=> !ser_out);
endmodule

// File: tb/test_strobe_reg_target.sv
module test_strobe_reg_target;
    localparam logic [31:0] VER  = 32'h5A3C_0107;
    localparam logic [31:0] MRST = 32'h0000_00C3;

    logic        ser_clk = 1'b0;
    logic        rst_n   = 1'b0;
    logic        stb_n   = 1'b1;
    logic        ser_in  = 1'b0;
    logic [31:0] sw_in   = 32'h1357_9BDF;
    logic        ser_out;
    logic [31:0] mode_cfg, mux_cfg, video_cfg;
    logic        sys_reset_req;

    int total = 0;
    int bad   = 0;
    logic [31:0] m_mode, m_mux, m_video, m_rst;

    strobe_reg_target #(.DATA_W(32), .ADDR_W(8), .VERSION(VER), .MODE_RESET(MRST))
    i_strobe_reg_target (
        .ser_clk(ser_clk), .rst_n(rst_n), .stb_n(stb_n), .ser_in(ser_in),
        .sw_in(sw_in), .ser_out(ser_out), .mode_cfg(mode_cfg), .mux_cfg(mux_cfg),
        .video_cfg(video_cfg), .sys_reset_req(sys_reset_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One 8 ns serial clock with the data line set beforehand.
    task automatic tick(input logic b);
        ser_in = b; #2; ser_clk = 1'b1; #4; ser_clk = 1'b0; #2;
    endtask

    task automatic strobe_clk(input logic dir);
        stb_n = 1'b0; ser_in = dir; #2; ser_clk = 1'b1; #4; ser_clk = 1'b0; #2;
        stb_n = 1'b1; ser_in = 1'b0;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        for (int i = 31; i >= 0; i--) tick(d[i]);
        for (int i = 7; i >= 0; i--) tick(a[i]);
        strobe_clk(1'b1);
    endtask

    // Read: every bit is sampled before its rising edge.
    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        for (int i = 7; i >= 0; i--) tick(a[i]);
        strobe_clk(1'b0);
        for (int i = 31; i >= 0; i--) begin
            ser_in = 1'b0; #2; d[i] = ser_out; ser_clk = 1'b1; #4; ser_clk = 1'b0; #2;
        end
    endtask

    function automatic logic [31:0] model_read(input logic [7:0] a);
        case (a)
            8'h00: return m_mode;
            8'h01: return m_mux;
            8'h02: return m_video;
            8'h08: return sw_in;
            8'h80: return m_rst;
            8'hFF: return VER;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check_outputs(input string req);
        check(req, mode_cfg, m_mode);
        check(req, mux_cfg, m_mux);
        check(req, video_cfg, m_video);
        check(req, {31'h0, sys_reset_req}, {31'h0, m_rst == 32'd1});
    endtask

    initial begin : watchdog
        #1_500_000;
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [31:0] rd;
        logic [31:0] pat;
        m_mode = MRST; m_mux = 0; m_video = 0; m_rst = 0;
        for (int i = 0; i < 4; i++) tick(1'b0);
        #1;
        // R1 reset state
        check("R1 ser_out", {31'h0, ser_out}, 32'h0);
        check_outputs("R1");
        rst_n = 1'b1;
        // R10 first transaction after reset (dummy version read)
        bus_read(8'hFF, rd);
        check("R10 first read", rd, VER);
        bus_read(8'hFF, rd);
        check("R6 version", rd, VER);
        // R2 basic writes
        bus_write(8'h00, 32'hDEAD_BEEF); m_mode = 32'hDEAD_BEEF;
        bus_write(8'h01, 32'h0F0F_1234); m_mux = 32'h0F0F_1234;
        bus_write(8'h02, 32'h8000_0001); m_video = 32'h8000_0001;
        check_outputs("R2");
        bus_read(8'h01, rd);
        check("R3 mux readback", rd, 32'h0F0F_1234);
        // R7 switch input
        bus_read(8'h08, rd);
        check("R7 switch", rd, sw_in);
        sw_in = 32'hFEDC_0123;
        bus_read(8'h08, rd);
        check("R7 switch change", rd, 32'hFEDC_0123);
        // R8 reset request
        bus_write(8'h80, 32'd1); m_rst = 32'd1;
        check("R8 req high", {31'h0, sys_reset_req}, 32'h1);
        bus_read(8'h80, rd);
        check("R8 readback", rd, 32'd1);
        bus_write(8'h80, 32'd3); m_rst = 32'd3;
        check("R8 req low", {31'h0, sys_reset_req}, 32'h0);
        // R9 clocks without strobe change nothing
        for (int i = 0; i < 40; i++) tick(i[0]);
        check_outputs("R9");
        bus_read(8'h02, rd);
        check("R9 video after stray clocks", rd, m_video);
        // R4/R5/R2/R3 sweep over every address
        for (int a = 0; a < 256; a++) begin
            pat = 32'hC0DE_0000 ^ {8'(a), 8'(a) ^ 8'h5A, ~8'(a), 8'(a)};
            bus_write(8'(a), pat);
            case (8'(a))
                8'h00: m_mode  = pat;
                8'h01: m_mux   = pat;
                8'h02: m_video = pat;
                8'h80: m_rst   = pat;
                default: ;
            endcase
            check_outputs("R4 sweep");
            bus_read(8'(a), rd);
            check("R5 sweep read", rd, model_read(8'(a)));
        end
        // R4 read-only writes leave version and switch readback alone
        bus_write(8'hFF, 32'h0);
        bus_read(8'hFF, rd);
        check("R4 version kept", rd, VER);
        bus_write(8'h08, 32'h0);
        bus_read(8'h08, rd);
        check("R4 switch kept", rd, sw_in);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule